// File: doc/BRIEF.md
# Receive Lookahead Copy Controller

This controller sequences the receive DMA of a network interface when lookahead buffering is used. Each frame waiting in the local receive buffer is copied to host memory in two separate passes. The first pass moves only a programmable number of leading dwords (the header). It then writes status back to the current descriptor and hands that descriptor to the host. The engine then parks. Software inspects the header and chooses one of two actions. It can re-arm the engine to fetch the whole frame into the next descriptor's buffer, or it can raise a skip flag so that the frame is discarded without another copy.

The host has two set-only controls. The arm bit lets the engine read descriptors and move data, and the engine clears it after every status post. The skip bit is cleared by the engine on every descriptor read. Frame payload is read from the local buffer by dword offset. It leaves toward the host on a valid/ready stream. A beat moves only on a cycle where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, `wr_valid` stays high and the beat presented does not change. The frame at the head of the local buffer is offered with `frm_valid`/`frm_len` and stays stable until the engine releases it with a one-cycle `frm_ready`.

Descriptors form a ring of 2^IDX_W entries, each four dwords long. The engine reads and writes only dword 0 of each entry. In that dword, bit 15 is ownership (1 = engine may use it), bits 31:16 carry the received byte length, and bit 0 marks a header-only post.

Top module: `rlc_lookahead`

## Requirements
- R1: After reset, arm and skip read 0 and `wr_valid`, `desc_rd`, `desc_we`, `frm_ready`, `thr_sts` and `early_rx` are all 0.
- R2: While arm is 0 the engine neither reads a descriptor nor presents data, even when a frame is waiting.
- R3: The header pass transfers min(H, ceil(L/4)) dwords, where H is `cfg_hdr_dw` (0 is treated as 1) and L is `frm_len`. The dwords are taken from buffer offsets 0, 1, 2, … in order, and `wr_last` is set on the final one.
- R4: At the end of the header pass the engine writes dword 0 of the current descriptor at `desc_addr` = 4·index. The value is L in bits 31:16, 0 in bit 15 and 1 in bit 0 when the frame is longer than H dwords. It then clears arm and advances the ring index by one, modulo the ring size.
- R5: A frame of at most H dwords is released with `frm_ready` in the header post cycle, and no second pass follows.
- R6: After a header-only post the engine stays idle until arm is set and then reads the next descriptor. If skip is set at that read, the frame is released with no further data and no post, and the descriptor is not consumed: the next header post lands on that same index.
- R7: Otherwise the second pass transfers all ceil(L/4) dwords from offset 0. It posts L with bits 15 and 0 both 0, releases the frame, clears arm and advances the index.
- R8: Skip is set by `host_skip_set` and cleared by every descriptor read.
- R9: A descriptor read that finds bit 15 at 0 pulses `ring_dry` and clears arm. No data moves, and the same descriptor is read again once arm is set, with the frame's progress kept.
- R10: `early_rx` pulses once per frame, on the beat after which min(4·beats of the current pass, L) first reaches or passes `cfg_thresh`.
- R11: `thr_sts` is 1 exactly while a pass is presenting data and min(4·beats already moved in that pass, L) ≥ `cfg_thresh`. It is 0 whenever no pass is active.
- R12: Every dword of a pass crosses exactly once and in offset order, whatever the `wr_ready` pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_arm_set | input | 1 | Host pulse setting arm |
| host_skip_set | input | 1 | Host pulse setting skip |
| cfg_hdr_dw | input | HDR_W | Header length in dwords |
| cfg_thresh | input | LEN_W | Early-receive byte threshold |
| arm_o | output | 1 | Current arm bit |
| skip_o | output | 1 | Current skip bit |
| frm_valid | input | 1 | A frame waits in the local buffer |
| frm_len | input | LEN_W | Byte length of the waiting frame |
| frm_ready | output | 1 | Frame released from the buffer |
| buf_addr | output | LEN_W-2 | Dword offset read from the local buffer |
| buf_data | input | DW | Local buffer data at `buf_addr` |
| wr_valid | output | 1 | Host-side beat valid |
| wr_ready | input | 1 | Host side accepts the beat |
| wr_data | output | DW | Host-side beat data |
| wr_last | output | 1 | Final beat of the pass |
| desc_addr | output | IDX_W+2 | Descriptor dword address |
| desc_rd | output | 1 | Descriptor read strobe |
| desc_rdata | input | LEN_W+16 | Descriptor dword 0, same cycle as the read |
| desc_we | output | 1 | Descriptor write strobe |
| desc_wdata | output | LEN_W+16 | Status written to dword 0 |
| early_rx | output | 1 | Early-receive pulse |
| thr_sts | output | 1 | Copy past threshold |
| ring_dry | output | 1 | Descriptor was not engine-owned |

## Verification
The embedded properties check, on every cycle, the rules that must hold at all times. No data moves without arm. A stalled beat holds. Each post and each dry-ring event clears arm. A release only happens while a frame is offered. The early pulse falls on a transferred beat. The threshold status stays inside a copy. The beat counts, the status words and their ring positions, skip handling that leaves a descriptor unconsumed, recovery from an unowned descriptor, and the once-per-frame rule for `early_rx` can only be shown by the bench. It sweeps frame length, header size and threshold under a throttled `wr_ready`.

// File: rtl/rlc_pkg.sv
`timescale 1ns/1ps
package rlc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HDESC, S_HCOPY, S_HPOST, S_PARK, S_BDESC, S_BCOPY, S_BPOST
  } rlc_state_e;
  localparam int unsigned OWN_POS  = 15;
  localparam int unsigned MORE_POS = 0;
endpackage

// File: rtl/rlc_host_bits.sv
`timescale 1ns/1ps
module rlc_host_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic arm_clr,
  input  logic skip_set,
  input  logic skip_clr,
  output logic arm,
  output logic skip
);
  // a host set in the same cycle as an engine clear wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm  <= 1'b0;
      skip <= 1'b0;
    end else begin
      if (arm_set)       arm <= 1'b1;
      else if (arm_clr)  arm <= 1'b0;
      if (skip_set)      skip <= 1'b1;
      else if (skip_clr) skip <= 1'b0;
    end
  end
endmodule

// File: rtl/rlc_copy_cnt.sv
`timescale 1ns/1ps
module rlc_copy_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             beat,
  input  logic             new_frame,
  input  logic             active,
  input  logic [LEN_W-1:0] frm_len,
  input  logic [LEN_W-1:0] thresh,
  output logic [LEN_W-2:0] beat_cnt,
  output logic             early_pulse,
  output logic             thr_hit
);
  localparam int CNT_W = LEN_W - 1;

  logic [CNT_W-1:0] cnt_inc;
  logic [LEN_W:0]   done_b, next_b, len_x, thr_x, done_clip, next_clip;
  logic             er_done;

  assign cnt_inc   = beat_cnt + 1'b1;
  assign done_b    = {beat_cnt, 2'b00};
  assign next_b    = {cnt_inc, 2'b00};
  assign len_x     = {1'b0, frm_len};
  assign thr_x     = {1'b0, thresh};
  assign done_clip = (done_b > len_x) ? len_x : done_b;
  assign next_clip = (next_b > len_x) ? len_x : next_b;

  assign early_pulse = beat && !er_done && (next_clip >= thr_x);
  assign thr_hit     = active && (done_clip >= thr_x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt <= '0;
      er_done  <= 1'b0;
    end else begin
      if (clear)     beat_cnt <= '0;
      else if (beat) beat_cnt <= cnt_inc;
      if (new_frame)        er_done <= 1'b0;
      else if (early_pulse) er_done <= 1'b1;
    end
  end
endmodule

// File: rtl/rlc_ctrl.sv
`timescale 1ns/1ps
module rlc_ctrl
  import rlc_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int HDR_W = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              skip,
  input  logic              frm_valid,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [HDR_W-1:0]  hdr_dw,
  input  logic [LEN_W+15:0] desc_rdata,
  input  logic              wr_ready,
  input  logic [LEN_W-2:0]  beat_cnt,
  output logic              desc_rd,
  output logic              desc_we,
  output logic [IDX_W-1:0]  desc_idx,
  output logic [LEN_W+15:0] desc_wdata,
  output logic              wr_valid,
  output logic              wr_last,
  output logic              frm_ready,
  output logic              arm_clr,
  output logic              skip_clr,
  output logic              dry_pulse,
  output logic              cnt_clear,
  output logic              new_frame,
  output logic              beat
);
  localparam int CNT_W = LEN_W - 1;

  rlc_state_e       state, nxt;
  logic [LEN_W:0]   len_pad;
  logic [CNT_W-1:0] fdw, hdr_eff, hb, target;
  logic             fits, owned, more, adv;
  logic             unused_rd;

  assign len_pad   = {1'b0, frm_len} + (LEN_W+1)'(3);
  assign fdw       = len_pad[LEN_W:2];
  assign hdr_eff   = (hdr_dw == '0) ? CNT_W'(1) : CNT_W'(hdr_dw);
  assign fits      = (fdw <= hdr_eff);
  assign hb        = fits ? fdw : hdr_eff;
  assign target    = (state == S_BCOPY) ? fdw : hb;
  assign owned     = desc_rdata[OWN_POS];
  assign unused_rd = ^{desc_rdata[LEN_W+15:OWN_POS+1], desc_rdata[OWN_POS-1:0]};

  assign wr_valid  = (state == S_HCOPY) || (state == S_BCOPY);
  assign beat      = wr_valid && wr_ready;
  assign wr_last   = ((beat_cnt + 1'b1) == target);
  assign desc_rd   = ((state == S_HDESC) || (state == S_BDESC)) && arm;
  assign cnt_clear = desc_rd;
  assign new_frame = (state == S_IDLE) && frm_valid;
  assign more      = (state == S_HPOST) && !fits;
  assign desc_wdata = {frm_len, 15'd0, more};

  always_comb begin
    nxt       = state;
    desc_we   = 1'b0;
    frm_ready = 1'b0;
    arm_clr   = 1'b0;
    skip_clr  = 1'b0;
    dry_pulse = 1'b0;
    adv       = 1'b0;
    case (state)
      S_IDLE:  if (frm_valid) nxt = S_HDESC;
      S_HDESC: if (arm) begin
        skip_clr = 1'b1;
        if (owned) nxt = S_HCOPY;
        else begin dry_pulse = 1'b1; arm_clr = 1'b1; end
      end
      S_HCOPY: if (beat && wr_last) nxt = S_HPOST;
      S_HPOST: begin
        desc_we = 1'b1; arm_clr = 1'b1; adv = 1'b1;
        if (fits) begin frm_ready = 1'b1; nxt = S_IDLE; end
        else nxt = S_PARK;
      end
      S_PARK:  if (arm) nxt = S_BDESC;
      S_BDESC: if (arm) begin
        skip_clr = 1'b1;
        if (skip) begin frm_ready = 1'b1; nxt = S_IDLE; end
        else if (owned) nxt = S_BCOPY;
        else begin dry_pulse = 1'b1; arm_clr = 1'b1; end
      end
      S_BCOPY: if (beat && wr_last) nxt = S_BPOST;
      S_BPOST: begin
        desc_we = 1'b1; arm_clr = 1'b1; adv = 1'b1; frm_ready = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      desc_idx <= '0;
    end else begin
      state <= nxt;
      if (adv) desc_idx <= desc_idx + 1'b1;
    end
  end

  AST_COPY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> arm); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(beat_cnt)); // R12
  AST_POST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |=> !desc_we); // R4
endmodule

// File: rtl/rlc_lookahead.sv
`timescale 1ns/1ps
module rlc_lookahead #(
  parameter int LEN_W = 16,
  parameter int HDR_W = 8,
  parameter int IDX_W = 3,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_arm_set,
  input  logic              host_skip_set,
  input  logic [HDR_W-1:0]  cfg_hdr_dw,
  input  logic [LEN_W-1:0]  cfg_thresh,
  output logic              arm_o,
  output logic              skip_o,
  input  logic              frm_valid,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              frm_ready,
  output logic [LEN_W-3:0]  buf_addr,
  input  logic [DW-1:0]     buf_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DW-1:0]     wr_data,
  output logic              wr_last,
  output logic [IDX_W+1:0]  desc_addr,
  output logic              desc_rd,
  input  logic [LEN_W+15:0] desc_rdata,
  output logic              desc_we,
  output logic [LEN_W+15:0] desc_wdata,
  output logic              early_rx,
  output logic              thr_sts,
  output logic              ring_dry
);
  localparam int CNT_W = LEN_W - 1;

  logic             arm_clr, skip_clr, cnt_clear, new_frame, beat;
  logic [IDX_W-1:0] desc_idx;
  logic [CNT_W-1:0] beat_cnt;
  logic             unused_cnt;

  rlc_host_bits u_bits (
    .clk(clk), .rst_n(rst_n),
    .arm_set(host_arm_set), .arm_clr(arm_clr),
    .skip_set(host_skip_set), .skip_clr(skip_clr),
    .arm(arm_o), .skip(skip_o)
  );

  rlc_copy_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .beat(beat),
    .new_frame(new_frame), .active(wr_valid), .frm_len(frm_len),
    .thresh(cfg_thresh), .beat_cnt(beat_cnt),
    .early_pulse(early_rx), .thr_hit(thr_sts)
  );

  rlc_ctrl #(.LEN_W(LEN_W), .HDR_W(HDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm_o), .skip(skip_o),
    .frm_valid(frm_valid), .frm_len(frm_len), .hdr_dw(cfg_hdr_dw),
    .desc_rdata(desc_rdata), .wr_ready(wr_ready), .beat_cnt(beat_cnt),
    .desc_rd(desc_rd), .desc_we(desc_we), .desc_idx(desc_idx),
    .desc_wdata(desc_wdata), .wr_valid(wr_valid), .wr_last(wr_last),
    .frm_ready(frm_ready), .arm_clr(arm_clr), .skip_clr(skip_clr),
    .dry_pulse(ring_dry), .cnt_clear(cnt_clear), .new_frame(new_frame),
    .beat(beat)
  );

  assign buf_addr   = beat_cnt[CNT_W-2:0];
  assign unused_cnt = beat_cnt[CNT_W-1];
  assign wr_data    = buf_data;
  assign desc_addr  = {desc_idx, 2'b00};

  AST_POST_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we && !host_arm_set |=> !arm_o); // R4
  AST_DRY_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ring_dry && !host_arm_set |=> !arm_o && !wr_valid); // R9
  AST_RELEASE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> frm_valid); // R5
  AST_THR_IN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    thr_sts |-> wr_valid); // R11
  AST_EARLY_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    early_rx |-> wr_valid && wr_ready); // R10
endmodule

// File: tb/rlc_lookahead_bench.sv
`timescale 1ns/1ps
module rlc_lookahead_bench;
  localparam int LEN_W = 16, HDR_W = 8, IDX_W = 3, DW = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic host_arm_set = 1'b0, host_skip_set = 1'b0;
  logic [HDR_W-1:0] cfg_hdr_dw = 8'd1;
  logic [LEN_W-1:0] cfg_thresh = 16'd1;
  logic arm_o, skip_o, frm_ready, wr_valid, wr_last, desc_rd, desc_we;
  logic early_rx, thr_sts, ring_dry;
  logic frm_valid = 1'b0;
  logic [LEN_W-1:0] frm_len = 16'd1;
  logic [LEN_W-3:0] buf_addr;
  logic [DW-1:0] buf_data, wr_data;
  logic wr_ready = 1'b1;
  logic [IDX_W+1:0] desc_addr;
  logic [LEN_W+15:0] desc_rdata, desc_wdata;
  logic [7:0] owned = 8'hFF;
  logic [15:0] cur_id = 16'd0;

  assign buf_data   = {cur_id, 2'b00, buf_addr};
  assign desc_rdata = {16'h0, owned[desc_addr[IDX_W+1:2]], 15'h0};

  rlc_lookahead #(.LEN_W(LEN_W), .HDR_W(HDR_W), .IDX_W(IDX_W), .DW(DW)) u_rlc_lookahead (
    .clk(clk), .rst_n(rst_n), .host_arm_set(host_arm_set),
    .host_skip_set(host_skip_set), .cfg_hdr_dw(cfg_hdr_dw),
    .cfg_thresh(cfg_thresh), .arm_o(arm_o), .skip_o(skip_o),
    .frm_valid(frm_valid), .frm_len(frm_len), .frm_ready(frm_ready),
    .buf_addr(buf_addr), .buf_data(buf_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .desc_addr(desc_addr), .desc_rd(desc_rd), .desc_rdata(desc_rdata),
    .desc_we(desc_we), .desc_wdata(desc_wdata), .early_rx(early_rx),
    .thr_sts(thr_sts), .ring_dry(ring_dry)
  );

  int n_chk = 0, n_err = 0;
  int cb, beats, posts, rels, dries, rds, ers, err_dat, err_er, err_thr;
  int w_addr, r_addr, rdy_cnt = 0, exp_idx = 0;
  int fL, fT, fdw, hb;
  longint w_data;
  bit er_model, hdr_phase, drop_pending = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clip(input int v);
    return (v > fL) ? fL : v;
  endfunction

  task automatic observe();
    int tgt;
    bit exp_e, exp_t;
    tgt = hdr_phase ? hb : fdw;
    if (desc_rd) begin cb = 0; rds++; r_addr = int'(desc_addr); end
    exp_t = wr_valid && (clip(4 * cb) >= fT);
    if (thr_sts !== exp_t) err_thr++;
    if (wr_valid && wr_ready) begin
      if (wr_data !== {cur_id, 2'b00, 14'(cb)}) err_dat++;
      if (wr_last !== ((cb + 1) == tgt)) err_dat++;
      exp_e = !er_model && (clip(4 * (cb + 1)) >= fT);
      if (early_rx !== exp_e) err_er++;
      if (exp_e) er_model = 1'b1;
      if (early_rx) ers++;
      cb++; beats++;
    end else if (early_rx) err_er++;
    if (desc_we) begin posts++; w_data = longint'(desc_wdata); w_addr = int'(desc_addr); hdr_phase = 1'b0; end
    if (frm_ready) begin rels++; drop_pending = 1'b1; end
    if (ring_dry) dries++;
  endtask

  task automatic tick();
    @(negedge clk);
    if (drop_pending) begin frm_valid = 1'b0; drop_pending = 1'b0; end
    rdy_cnt++;
    wr_ready = (rdy_cnt % 5) != 4;
    #1;
    observe();
  endtask

  task automatic pulse_arm();
    host_arm_set = 1'b1; tick(); host_arm_set = 1'b0;
  endtask

  task automatic run_frame(input int L, input int H, input int T, input int mode);
    int heff;
    bit fits;
    fL = L; fT = T; fdw = (L + 3) / 4;
    heff = (H == 0) ? 1 : H;
    fits = fdw <= heff;
    hb = fits ? fdw : heff;
    cb = 0; beats = 0; posts = 0; rels = 0; dries = 0; rds = 0; ers = 0;
    err_dat = 0; err_er = 0; err_thr = 0; er_model = 1'b0; hdr_phase = 1'b1;
    cfg_hdr_dw = 8'(H); cfg_thresh = 16'(T);
    cur_id = cur_id + 1'b1; frm_len = 16'(L); frm_valid = 1'b1;
    pulse_arm();
    while (posts < 1) tick();
    chk(beats == hb, "R3 header beats", beats, hb);
    chk(w_data == ((longint'(L) << 16) | longint'(!fits)), "R4 header status", w_data,
        (longint'(L) << 16) | longint'(!fits));
    chk(w_addr == exp_idx * 4, "R4 header slot", w_addr, exp_idx * 4);
    tick();
    chk(arm_o == 1'b0, "R4 arm cleared", arm_o, 0);
    exp_idx = (exp_idx + 1) % 8;
    if (fits) begin
      chk(rels == 1, "R5 short frame released", rels, 1);
    end else begin
      repeat (6) tick();
      chk(beats == hb && rds == 1 && rels == 0, "R6 parked quiet", beats + rds, hb + 1);
      if (mode == 1) begin
        host_skip_set = 1'b1; tick(); host_skip_set = 1'b0;
        chk(skip_o == 1'b1, "R8 skip set", skip_o, 1);
        pulse_arm();
        while (rels < 1) tick();
        tick();
        chk(beats == hb && posts == 1, "R6 skip moves nothing", beats, hb);
        chk(skip_o == 1'b0, "R8 skip cleared by read", skip_o, 0);
        chk(r_addr == exp_idx * 4, "R6 skip read slot", r_addr, exp_idx * 4);
      end else begin
        if (mode == 2) begin
          owned[exp_idx] = 1'b0;
          pulse_arm();
          while (dries < 1) tick();
          repeat (4) tick();
          chk(arm_o == 1'b0 && beats == hb, "R9 dry ring stalls", beats, hb);
          owned[exp_idx] = 1'b1;
        end
        pulse_arm();
        while (posts < 2) tick();
        chk(beats == hb + fdw, "R7 body beats", beats, hb + fdw);
        chk(w_data == (longint'(L) << 16), "R7 body status", w_data, longint'(L) << 16);
        chk(w_addr == exp_idx * 4 && rels == 1, "R7 body slot", w_addr, exp_idx * 4);
        exp_idx = (exp_idx + 1) % 8;
        tick();
      end
    end
    tick();
    chk(err_dat == 0, "R12 data order", err_dat, 0);
    chk(err_er == 0 && ers == int'(er_model), "R10 early pulse", ers, int'(er_model));
    chk(err_thr == 0, "R11 threshold status", err_thr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(arm_o == 0 && skip_o == 0, "R1 reset bits", {arm_o, skip_o}, 0);
    chk(!wr_valid && !desc_rd && !desc_we && !frm_ready && !thr_sts && !early_rx,
        "R1 reset outputs", {wr_valid, desc_rd, desc_we, frm_ready}, 0);
    fL = 8; fT = 100; fdw = 2; hb = 1; hdr_phase = 1'b1;
    rds = 0; beats = 0;
    cur_id = 16'd1; frm_len = 16'd8; frm_valid = 1'b1;
    repeat (8) tick();
    chk(rds == 0 && beats == 0, "R2 no arm no activity", rds + beats, 0);
    frm_valid = 1'b0; cur_id = 16'd0;
    tick();
    for (int L = 1; L <= 21; L++)
      for (int hi = 0; hi < 3; hi++)
        for (int ti = 0; ti < 3; ti++) begin
          int H, T;
          H = (hi == 0) ? 1 : (hi == 1) ? 2 : 4;
          T = (ti == 0) ? 3 : (ti == 1) ? 9 : 30;
          run_frame(L, H, T, (L + hi + ti) % 3);
        end
    run_frame(13, 0, 2, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule